// File: doc/BRIEF.md
# Pipeline Exception Entry Controller

This block decides, cycle by cycle, whether a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) of a 32-bit core has to leave its sequential path. The pipeline reports a software trap found in decode, a prefetch abort or a branch-with-link that has reached execute, a data abort from the memory stage, and an interrupt request line. Each stage also reports its instruction address and a valid bit. In the same cycle, the block returns a redirect strobe with the new fetch address, a stage flush mask, a cause code, and the value to write into the banked link register.

Each event kind is detected in a different stage. For that reason the saved link value has a kind-specific offset from the instruction it concerns, and the return sequence of each handler depends on it:

| Event | Handler return |
|---|---|
| Data abort | Returns with link minus 8, which re-runs the faulting access. |
| Prefetch abort | Returns with link minus 4. |
| Interrupt | Returns with link minus 4. |
| Software trap | Copies link straight into the PC. |
| Branch-with-link callee | Copies link straight into the PC. |

The step between instructions is 4 bytes in normal mode and 2 bytes in compact mode.

Control is a two-state machine:

- ST_RUN accepts all events.
- ST_REFILL holds off the interrupt line while the handler's first instructions travel from fetch to execute.

The transitions are:

- RUN→REFILL is taken on any exception entry. A branch-with-link does not cause it.
- REFILL→REFILL reloads the counter on a further exception entry.
- REFILL→RUN is taken when the refill counter is exhausted.

A shadow of the last flush mask marks the stages that hold squashed instructions in the next cycle. Flags from those stages are discarded. The pipeline is assumed to advance every cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, no redirect and no link write occur whatever the flags are. After reset is released, the controller is in ST_RUN and an interrupt is accepted in the first cycle it is requested.
- R2: A data abort on a valid memory-stage instruction redirects to 0x10 with cause code 1. The flush mask is 4'b1111. The link value is the memory-stage address plus 8 in both modes.
- R3: A prefetch abort flagged on a valid execute-stage instruction redirects to 0x0C with cause code 2. The flush mask is 4'b0111. The link value is the execute-stage address plus 4.
- R4: A software trap on a valid decode-stage instruction redirects to 0x08 with cause code 5. The flush mask is 4'b0011. The link value is the decode-stage address plus the instruction step (4 normal, 2 compact).
- R5: An interrupt is taken only while execute holds a valid instruction. It redirects to 0x18 with cause code 4 and flush mask 4'b0011. The link value is the execute-stage address plus the step plus 4.
- R6: A branch-with-link in a valid execute stage redirects to the supplied target with cause code 3 and flush mask 4'b0011. The link value is the execute-stage address plus the step.
- R7: Events in the same cycle are resolved in this fixed order: data abort, prefetch abort, branch-with-link, interrupt, software trap. Only the winner is reported.
- R8: A flag raised by a stage whose valid bit is low has no effect.
- R9: In the cycle after a redirect, the following flags are ignored:
  - decode-stage flags, if fetch was flushed;
  - execute-stage flags, if decode was flushed;
  - memory-stage flags, if execute was flushed.
- R10: After an exception entry, the interrupt is held off for 3 cycles (REFILL_CYC) and is accepted in the 4th cycle. A branch-with-link starts no hold-off.
- R11: Redirect, link write, cause, link value, target and flush mask appear combinationally in the same cycle as the winning flag. `redir_o` and `link_we_o` are equal. Flush bit 0 is fetch, bit 1 decode, bit 2 execute and bit 3 memory, and every redirect sets bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmode_i | input | 1 | 1 = compact 2-byte instruction mode |
| irq_i | input | 1 | Interrupt request, level |
| dabt_m_i | input | 1 | Data abort on memory-stage instruction |
| pabt_e_i | input | 1 | Prefetch abort carried by execute-stage instruction |
| swi_d_i | input | 1 | Software trap decoded in decode stage |
| bl_e_i | input | 1 | Branch-with-link in execute stage |
| bl_tgt_i | input | 32 | Branch-with-link target address |
| d_vld_i | input | 1 | Decode stage holds an instruction |
| e_vld_i | input | 1 | Execute stage holds an instruction |
| m_vld_i | input | 1 | Memory stage holds an instruction |
| d_pc_i | input | 32 | Decode-stage instruction address |
| e_pc_i | input | 32 | Execute-stage instruction address |
| m_pc_i | input | 32 | Memory-stage instruction address |
| redir_o | output | 1 | Redirect the fetch unit this cycle |
| redir_pc_o | output | 32 | New fetch address (vector or branch target) |
| flush_o | output | 4 | Stage flush mask {mem, exe, dec, fetch} |
| link_we_o | output | 1 | Write link register this cycle |
| link_o | output | 32 | Value for the link register |
| cause_o | output | 3 | Cause code of the redirect, 0 when none |

## Verification
Several events can fall in the same cycle. One case pits a data abort from the memory stage against younger events in execute and decode: prefetch abort, branch-with-link, interrupt and software trap. Another pits an interrupt against a branch-with-link or software trap. The vector table raises these flags together on a fully valid pipeline and judges the cause code, vector and link value against the fixed order.

A second collision crosses cycles: a fault raised just after a redirect, by an instruction that sits in a squashed slot or that had already completed. Directed sequences fire a fault in the cycle right after an interrupt, prefetch abort or branch-with-link. They expect it to be dropped or taken according to which stages the previous flush covered.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // cause codes reported on cause_o
    typedef enum logic [2:0] {
        CS_NONE = 3'd0,
        CS_DABT = 3'd1,
        CS_PABT = 3'd2,
        CS_BL   = 3'd3,
        CS_IRQ  = 3'd4,
        CS_SWI  = 3'd5
    } cause_e;

    // controller states
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_REFILL = 1'b1
    } ctl_st_e;

    // number of flushable stages and their bit positions
    localparam int NFL     = 4;
    localparam int FL_FET  = 0;
    localparam int FL_DEC  = 1;
    localparam int FL_EXE  = 2;
    localparam int FL_MEM  = 3;

    // number of competing events
    localparam int NEVT = 5;

    // qualified events, one bit each, in priority order (MSB wins)
    typedef struct packed {
        logic dabt;
        logic pabt;
        logic bl;
        logic irq;
        logic swi;
    } evt_s;

endpackage

// File: rtl/exc_stage_qual.sv
module exc_stage_qual
    import exc_pkg::*;
(
    input  logic       rst_n,
    input  logic       irq_i,
    input  logic       dabt_m_i,
    input  logic       pabt_e_i,
    input  logic       swi_d_i,
    input  logic       bl_e_i,
    input  logic       d_vld_i,
    input  logic       e_vld_i,
    input  logic       m_vld_i,
    input  logic [2:0] bubble_i,   // [0] decode, [1] execute, [2] memory squashed
    input  logic       irq_hold_i,
    output evt_s       evt_o
);

    logic d_live;
    logic e_live;
    logic m_live;

    always_comb begin
        d_live = rst_n && d_vld_i && !bubble_i[0];
        e_live = rst_n && e_vld_i && !bubble_i[1];
        m_live = rst_n && m_vld_i && !bubble_i[2];

        evt_o.dabt = dabt_m_i && m_live;
        evt_o.pabt = pabt_e_i && e_live;
        evt_o.bl   = bl_e_i   && e_live;
        evt_o.irq  = irq_i    && e_live && !irq_hold_i;
        evt_o.swi  = swi_d_i  && d_live;
    end

endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
    import exc_pkg::*;
(
    input  evt_s   evt_i,
    output cause_e cause_o
);

    localparam cause_e ORDER [NEVT] = '{CS_SWI, CS_IRQ, CS_BL, CS_PABT, CS_DABT};

    logic [NEVT-1:0] req;
    cause_e          pick [NEVT+1];

    assign req     = evt_i;
    assign pick[0] = CS_NONE;

    // ripple from lowest to highest priority; a higher bit overrides
    for (genvar g = 0; g < NEVT; g++) begin : g_chain
        assign pick[g+1] = req[g] ? ORDER[g] : pick[g];
    end

    assign cause_o = pick[NEVT];

endmodule

// File: rtl/exc_link_calc.sv
module exc_link_calc
    import exc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_SWI  = 'h08,
    parameter logic [AW-1:0] VEC_PABT = 'h0C,
    parameter logic [AW-1:0] VEC_DABT = 'h10,
    parameter logic [AW-1:0] VEC_IRQ  = 'h18
) (
    input  cause_e          cause_i,
    input  logic            cmode_i,
    input  logic [AW-1:0]   d_pc_i,
    input  logic [AW-1:0]   e_pc_i,
    input  logic [AW-1:0]   m_pc_i,
    input  logic [AW-1:0]   bl_tgt_i,
    output logic [AW-1:0]   link_o,
    output logic [AW-1:0]   target_o,
    output logic [NFL-1:0]  flush_o
);

    localparam logic [AW-1:0] STEP_FULL = AW'(4);
    localparam logic [AW-1:0] STEP_HALF = AW'(2);
    localparam logic [AW-1:0] AHEAD     = AW'(8);   // read-PC offset for faulting accesses
    localparam logic [AW-1:0] WORD      = AW'(4);

    localparam logic [NFL-1:0] FL_FRONT = NFL'(2'b11);
    localparam logic [NFL-1:0] FL_TOEXE = NFL'(3'b111);
    localparam logic [NFL-1:0] FL_ALL   = {NFL{1'b1}};

    logic [AW-1:0] step;

    assign step = cmode_i ? STEP_HALF : STEP_FULL;

    always_comb begin
        link_o   = '0;
        target_o = '0;
        flush_o  = '0;
        unique case (cause_i)
            CS_DABT: begin
                link_o   = m_pc_i + AHEAD;
                target_o = VEC_DABT;
                flush_o  = FL_ALL;
            end
            CS_PABT: begin
                link_o   = e_pc_i + WORD;
                target_o = VEC_PABT;
                flush_o  = FL_TOEXE;
            end
            CS_BL: begin
                link_o   = e_pc_i + step;
                target_o = bl_tgt_i;
                flush_o  = FL_FRONT;
            end
            CS_IRQ: begin
                link_o   = e_pc_i + step + WORD;
                target_o = VEC_IRQ;
                flush_o  = FL_FRONT;
            end
            CS_SWI: begin
                link_o   = d_pc_i + step;
                target_o = VEC_SWI;
                flush_o  = FL_FRONT;
            end
            CS_NONE: begin
                link_o   = '0;
                target_o = '0;
                flush_o  = '0;
            end
            default: begin
                link_o   = '0;
                target_o = '0;
                flush_o  = '0;
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            REFILL_CYC = 3,
    parameter logic [AW-1:0] VEC_SWI    = 'h08,
    parameter logic [AW-1:0] VEC_PABT   = 'h0C,
    parameter logic [AW-1:0] VEC_DABT   = 'h10,
    parameter logic [AW-1:0] VEC_IRQ    = 'h18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmode_i,
    input  logic          irq_i,
    input  logic          dabt_m_i,
    input  logic          pabt_e_i,
    input  logic          swi_d_i,
    input  logic          bl_e_i,
    input  logic [AW-1:0] bl_tgt_i,
    input  logic          d_vld_i,
    input  logic          e_vld_i,
    input  logic          m_vld_i,
    input  logic [AW-1:0] d_pc_i,
    input  logic [AW-1:0] e_pc_i,
    input  logic [AW-1:0] m_pc_i,
    output logic          redir_o,
    output logic [AW-1:0] redir_pc_o,
    output logic [3:0]    flush_o,
    output logic          link_we_o,
    output logic [AW-1:0] link_o,
    output logic [2:0]    cause_o
);

    localparam int            CW       = (REFILL_CYC < 2) ? 1 : $clog2(REFILL_CYC);
    localparam logic [CW-1:0] CNT_LOAD = CW'(REFILL_CYC - 1);

    ctl_st_e        st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [2:0]     bub_q, bub_d;

    evt_s           evt;
    cause_e         cause;
    logic [AW-1:0]  link_w;
    logic [AW-1:0]  tgt_w;
    logic [NFL-1:0] flush_w;
    logic           take;
    logic           exc_entry;
    logic           irq_hold;

    assign irq_hold  = (st_q == ST_REFILL);
    assign take      = (cause != CS_NONE);
    assign exc_entry = take && (cause != CS_BL);

    exc_stage_qual u_qual (
        .rst_n      (rst_n),
        .irq_i      (irq_i),
        .dabt_m_i   (dabt_m_i),
        .pabt_e_i   (pabt_e_i),
        .swi_d_i    (swi_d_i),
        .bl_e_i     (bl_e_i),
        .d_vld_i    (d_vld_i),
        .e_vld_i    (e_vld_i),
        .m_vld_i    (m_vld_i),
        .bubble_i   (bub_q),
        .irq_hold_i (irq_hold),
        .evt_o      (evt)
    );

    exc_prio_arb u_arb (
        .evt_i   (evt),
        .cause_o (cause)
    );

    exc_link_calc #(
        .AW       (AW),
        .VEC_SWI  (VEC_SWI),
        .VEC_PABT (VEC_PABT),
        .VEC_DABT (VEC_DABT),
        .VEC_IRQ  (VEC_IRQ)
    ) u_link (
        .cause_i  (cause),
        .cmode_i  (cmode_i),
        .d_pc_i   (d_pc_i),
        .e_pc_i   (e_pc_i),
        .m_pc_i   (m_pc_i),
        .bl_tgt_i (bl_tgt_i),
        .link_o   (link_w),
        .target_o (tgt_w),
        .flush_o  (flush_w)
    );

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        // a flushed stage k leaves a bubble in stage k+1 next cycle
        bub_d = take ? flush_w[FL_EXE:FL_FET] : 3'b000;
        unique case (st_q)
            ST_RUN: begin
                if (exc_entry) begin
                    st_d  = ST_REFILL;
                    cnt_d = CNT_LOAD;
                end
            end
            ST_REFILL: begin
                if (exc_entry) begin
                    st_d  = ST_REFILL;
                    cnt_d = CNT_LOAD;
                end else if (cnt_q == '0) begin
                    st_d  = ST_RUN;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: begin
                st_d  = ST_RUN;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
            bub_q <= 3'b000;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            bub_q <= bub_d;
        end
    end

    // outputs
    always_comb begin
        redir_o    = take;
        link_we_o  = take;
        redir_pc_o = tgt_w;
        link_o     = link_w;
        flush_o    = flush_w;
        cause_o    = cause;
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int            AW         = 32,
    parameter int            REFILL_CYC = 3,
    parameter logic [AW-1:0] VEC_DABT   = 'h10,
    parameter logic [AW-1:0] VEC_IRQ    = 'h18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmode_i,
    input logic          dabt_m_i,
    input logic          m_vld_i,
    input logic [AW-1:0] e_pc_i,
    input logic [AW-1:0] m_pc_i,
    input logic [AW-1:0] bl_tgt_i,
    input logic          redir_o,
    input logic [AW-1:0] redir_pc_o,
    input logic [3:0]    flush_o,
    input logic          link_we_o,
    input logic [AW-1:0] link_o,
    input logic [2:0]    cause_o
);

    logic prev_fl_fet;
    logic prev_fl_exe;
    int   hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_fl_fet <= 1'b0;
            prev_fl_exe <= 1'b0;
            hold        <= 0;
        end else begin
            prev_fl_fet <= redir_o && flush_o[0];
            prev_fl_exe <= redir_o && flush_o[2];
            if (redir_o && cause_o != 3'd3 && cause_o != 3'd0)
                hold <= REFILL_CYC;
            else if (hold != 0)
                hold <= hold - 1;
        end
    end

    // R1: quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!redir_o && !link_we_o);
        end
    end

    // R2: data abort from a live memory stage wins with its own vector and link
    a_r2_dabt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (dabt_m_i && m_vld_i && !prev_fl_exe) |->
        (redir_o && cause_o == 3'd1 && flush_o == 4'hF
         && link_o == m_pc_i + AW'(8) && redir_pc_o == VEC_DABT));

    // R5: interrupt link and vector
    a_r5_irq_link: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o == 3'd4) |->
        (redir_pc_o == VEC_IRQ && link_o == e_pc_i + (cmode_i ? AW'(6) : AW'(8))));

    // R6: branch-with-link goes to the target and keeps execute
    a_r6_bl_target: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o == 3'd3) |-> (redir_pc_o == bl_tgt_i && !flush_o[2] && !flush_o[3]));

    // R9: no software trap from a decode slot that was squashed last cycle
    a_r9_dec_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        prev_fl_fet |-> (cause_o != 3'd5));

    // R10: no interrupt during the refill window
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold != 0) |-> (cause_o != 3'd4));

    // R11: every redirect clears fetch and decode and writes the link
    a_r11_front_flush: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (flush_o[1:0] == 2'b11 && link_we_o));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .AW         (AW),
    .REFILL_CYC (REFILL_CYC),
    .VEC_DABT   (VEC_DABT),
    .VEC_IRQ    (VEC_IRQ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmode_i    (cmode_i),
    .dabt_m_i   (dabt_m_i),
    .m_vld_i    (m_vld_i),
    .e_pc_i     (e_pc_i),
    .m_pc_i     (m_pc_i),
    .bl_tgt_i   (bl_tgt_i),
    .redir_o    (redir_o),
    .redir_pc_o (redir_pc_o),
    .flush_o    (flush_o),
    .link_we_o  (link_we_o),
    .link_o     (link_o),
    .cause_o    (cause_o)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmode_i = 1'b0;
    logic        irq_i = 1'b0;
    logic        dabt_m_i = 1'b0;
    logic        pabt_e_i = 1'b0;
    logic        swi_d_i = 1'b0;
    logic        bl_e_i = 1'b0;
    logic [31:0] bl_tgt_i = 32'h4000;
    logic        d_vld_i = 1'b0;
    logic        e_vld_i = 1'b0;
    logic        m_vld_i = 1'b0;
    logic [31:0] d_pc_i = '0;
    logic [31:0] e_pc_i = '0;
    logic [31:0] m_pc_i = '0;
    logic        redir_o;
    logic [31:0] redir_pc_o;
    logic [3:0]  flush_o;
    logic        link_we_o;
    logic [31:0] link_o;
    logic [2:0]  cause_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmode_i(cmode_i), .irq_i(irq_i),
        .dabt_m_i(dabt_m_i), .pabt_e_i(pabt_e_i), .swi_d_i(swi_d_i),
        .bl_e_i(bl_e_i), .bl_tgt_i(bl_tgt_i), .d_vld_i(d_vld_i),
        .e_vld_i(e_vld_i), .m_vld_i(m_vld_i), .d_pc_i(d_pc_i),
        .e_pc_i(e_pc_i), .m_pc_i(m_pc_i), .redir_o(redir_o),
        .redir_pc_o(redir_pc_o), .flush_o(flush_o), .link_we_o(link_we_o),
        .link_o(link_o), .cause_o(cause_o)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        cm, irq, dabt, pabt, swi, bl, dv, ev, mv;
        logic [31:0] mpc;
        logic        xr;
        logic [2:0]  xc;
        logic [3:0]  xf;
        logic [31:0] xl;
        logic [31:0] xp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{"R2",  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd1,4'hF,32'h1008,32'h10},
        '{"R3",  1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd2,4'h7,32'h1008,32'h0C},
        '{"R4",  1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd5,4'h3,32'h100C,32'h08},
        '{"R4",  1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 32'h2000, 1'b1,3'd5,4'h3,32'h2006,32'h08},
        '{"R5",  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd4,4'h3,32'h100C,32'h18},
        '{"R5",  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h2000, 1'b1,3'd4,4'h3,32'h2008,32'h18},
        '{"R6",  1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd3,4'h3,32'h1008,32'h4000},
        '{"R6",  1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 32'h2000, 1'b1,3'd3,4'h3,32'h2004,32'h4000},
        '{"R7",  1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd1,4'hF,32'h1008,32'h10},
        '{"R7",  1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd2,4'h7,32'h1008,32'h0C},
        '{"R7",  1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd3,4'h3,32'h1008,32'h4000},
        '{"R7",  1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1, 32'h1000, 1'b1,3'd4,4'h3,32'h100C,32'h18},
        '{"R8",  1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 32'h1000, 1'b0,3'd0,4'h0,32'h0,32'h0},
        '{"R8",  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 32'h1000, 1'b0,3'd0,4'h0,32'h0,32'h0},
        '{"R8",  1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 32'h1000, 1'b0,3'd0,4'h0,32'h0,32'h0},
        '{"R2",  1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 32'h2000, 1'b1,3'd1,4'hF,32'h2008,32'h10}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic quiet();
        irq_i = 0; dabt_m_i = 0; pabt_e_i = 0; swi_d_i = 0; bl_e_i = 0;
        d_vld_i = 1; e_vld_i = 1; m_vld_i = 1;
    endtask

    task automatic set_pcs(input logic cm, input logic [31:0] m);
        cmode_i = cm;
        m_pc_i = m;
        e_pc_i = m + (cm ? 32'd2 : 32'd4);
        d_pc_i = m + (cm ? 32'd4 : 32'd8);
    endtask

    // advance to the next cycle and let inputs settle after the edge
    task automatic next();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        quiet();
        for (int i = 0; i < n; i++) next();
    endtask

    task automatic expect_none(input string req);
        #4;
        chk(req, "redir", {31'b0, redir_o}, 32'd0);
        chk(req, "cause", {29'b0, cause_o}, 32'd0);
    endtask

    task automatic expect_hit(input string req, input logic [2:0] c, input logic [31:0] l);
        #4;
        chk(req, "redir", {31'b0, redir_o}, 32'd1);
        chk(req, "cause", {29'b0, cause_o}, {29'b0, c});
        chk(req, "link", link_o, l);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: flags during reset have no effect
        set_pcs(1'b0, 32'h1000);
        next();
        dabt_m_i = 1; m_vld_i = 1; swi_d_i = 1; d_vld_i = 1;
        #4;
        chk("R1", "redir in reset", {31'b0, redir_o}, 32'd0);
        chk("R1", "link_we in reset", {31'b0, link_we_o}, 32'd0);
        quiet();
        next();
        rst_n = 1;
        // R1: interrupt accepted in first cycle after reset
        quiet(); irq_i = 1;
        expect_hit("R1", 3'd4, 32'h100C);
        idle(6);

        // table walk
        for (int k = 0; k < NV; k++) begin
            set_pcs(VT[k].cm, VT[k].mpc);
            irq_i = VT[k].irq; dabt_m_i = VT[k].dabt; pabt_e_i = VT[k].pabt;
            swi_d_i = VT[k].swi; bl_e_i = VT[k].bl;
            d_vld_i = VT[k].dv; e_vld_i = VT[k].ev; m_vld_i = VT[k].mv;
            #4;
            chk(string'(VT[k].tag), "redir", {31'b0, redir_o}, {31'b0, VT[k].xr});
            chk(string'(VT[k].tag), "link_we", {31'b0, link_we_o}, {31'b0, VT[k].xr});
            chk(string'(VT[k].tag), "cause", {29'b0, cause_o}, {29'b0, VT[k].xc});
            chk(string'(VT[k].tag), "flush", {28'b0, flush_o}, {28'b0, VT[k].xf});
            if (VT[k].xr) begin
                chk(string'(VT[k].tag), "link", link_o, VT[k].xl);
                chk(string'(VT[k].tag), "target", redir_pc_o, VT[k].xp);
            end
            idle(6);
        end

        // R10: interrupt held for three cycles after a data abort
        set_pcs(1'b0, 32'h3000);
        quiet(); dabt_m_i = 1;
        expect_hit("R10", 3'd1, 32'h3008);
        next(); quiet(); irq_i = 1;
        expect_none("R9");          // execute slot squashed
        next(); expect_none("R10"); // hold cycle 2
        next(); expect_none("R10"); // hold cycle 3
        next(); expect_hit("R10", 3'd4, 32'h300C);
        idle(6);

        // R9 and R10: branch-with-link, then interrupt
        quiet(); bl_e_i = 1;
        expect_hit("R6", 3'd3, 32'h3008);
        next(); quiet(); irq_i = 1;
        expect_none("R9");          // execute holds squashed decode slot
        next(); expect_hit("R10", 3'd4, 32'h300C);  // no hold after a branch
        idle(6);

        // R9: software trap right after interrupt is dropped
        quiet(); irq_i = 1;
        expect_hit("R5", 3'd4, 32'h300C);
        next(); quiet(); swi_d_i = 1;
        expect_none("R9");
        idle(6);

        // R9: data abort right after interrupt is taken (memory slot was not squashed)
        quiet(); irq_i = 1;
        expect_hit("R5", 3'd4, 32'h300C);
        next(); quiet(); dabt_m_i = 1;
        expect_hit("R9", 3'd1, 32'h3008);
        idle(6);

        // R9: data abort right after prefetch abort is dropped
        quiet(); pabt_e_i = 1;
        expect_hit("R3", 3'd2, 32'h3008);
        next(); quiet(); dabt_m_i = 1;
        expect_none("R9");
        idle(6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule